// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a 64-bit input address into a physical address by walking a tree of 64-bit descriptors in memory. The translation granule is 4 KB, so each table holds 512 descriptors. Each level of the walk uses nine bits of the input address. A request is accepted on a valid/ready port. At acceptance the block does three things: it picks one of two translation regions from live configuration inputs, it works out the start level, and it works out the aligned base of the first table.

The block then issues one descriptor read at a time on a valid/ready memory request port. Each read is answered by exactly one response beat. Every descriptor is classified as a table, a block, a page or a bad entry, and is checked against the access type. A table descriptor sends the walk one level down. A leaf descriptor ends it.

The outcome is held on a valid/ready result port until the consumer takes it. The outcome is one of two things:
- the translated address together with its permissions, or
- a fault code together with the address of the descriptor that caused it.

Back-pressure rules:
- A new request is taken only while `req_ready` is high, which is only while the walker is idle.
- The memory request and its address stay unchanged until `mem_req_ready` is seen.
- Responses carry no ready and must only arrive for a granted read.
- The result and all of its fields stay unchanged until `res_ready` is seen.

Top module: `ptw_walker`

## Requirements
- R1: Region selection uses the top-byte-ignore flag of region 1 when input bit 55 is 1, and that of region 0 otherwise. When the flag is set, bits [63:56] are left out of the check. The check covers input bits from 64-size up to the top checked bit. Region 0 wins if its size field is non-zero and all checked bits are 0. Region 1 wins next if its size field is non-zero and all checked bits are 1. Failing both, a region with a zero size field takes the address, region 0 first. Otherwise the result is a translation fault (code 1) with no memory read.
- R2: If the selected region is disabled, the result is a translation fault with no memory read.
- R3: The input size is 64 minus the selected size field. It must lie in 13..48, otherwise the result is a translation fault with no read. The start level is 4 - (input size - 4) / 9, using integer division.
- R4: At the start level, the table base is bits [47:0] of the region base with the low (input size - 9*(4 - start level)) bits cleared. At lower levels, the base is bits [47:12] of the table descriptor, with bits [11:0] zero. The descriptor address is base + 8*index. The index is input bits [s+8:s] of the address, after the address is masked to the input size. Here s = 12 + 9*(3 - level).
- R5: A read response with the error flag set gives a walk-abort fault (code 3). The fault address is the descriptor address. This holds whatever the returned data says.
- R6: Descriptor bits [1:0] decide the kind. Values 00 and 10 are invalid. Value 01 is a block at levels 0..2 and reserved at level 3. Value 11 is a table at levels 0..2 and a page at level 3. Invalid or reserved entries give a translation fault carrying the descriptor address.
- R7: Bit 7 of a block or page descriptor marks it read-only. A write to a read-only leaf gives a permission fault (code 2). On success, `res_perm` bit 0 (read) is 1 and bit 1 (write) is the inverse of bit 7.
- R8: Bit 62 of a table descriptor marks everything below it read-only. A write through such a table gives a permission fault carrying that descriptor's address.
- R9: On success (code 0), the output address is descriptor bits [47:s], shifted back to position s, combined with the input address bits [s-1:0]. Here s is the shift of the level where the leaf was found. `res_mask` equals 0xFFF.
- R10: On any fault, `res_perm` and `res_oaddr` are 0. Faults found before any read report fault address 0. A successful walk also reports fault address 0.
- R11: After reset, `req_ready` is 1 and both `res_valid` and `mem_req_valid` are 0. At most one read is outstanding at any time. A stalled memory request and a stalled result both hold all of their fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tsz0 | input | 6 | Region 0 size field |
| cfg_tsz1 | input | 6 | Region 1 size field |
| cfg_tbi0 | input | 1 | Region 0 top-byte-ignore |
| cfg_tbi1 | input | 1 | Region 1 top-byte-ignore |
| cfg_off0 | input | 1 | Region 0 disabled |
| cfg_off1 | input | 1 | Region 1 disabled |
| cfg_base0 | input | 64 | Region 0 table base |
| cfg_base1 | input | 64 | Region 1 table base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 64 | Input address |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Descriptor address |
| mem_rsp_valid | input | 1 | Read response beat |
| mem_rsp_data | input | 64 | Descriptor read |
| mem_rsp_err | input | 1 | Read failed |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_fault | output | 2 | 0 ok, 1 translation, 2 permission, 3 walk abort |
| res_oaddr | output | 64 | Translated address |
| res_mask | output | 64 | Page offset mask |
| res_perm | output | 2 | Bit 0 read, bit 1 write |
| res_fault_addr | output | PA_W | Faulting descriptor address |

## Verification
The two functions that can fall in the same cycle are the error flag on a response beat and the classification of that beat's data word. A response beat may carry both an error flag and a data word that would classify on its own as table, page or a permission failure. The bench memory model always returns a hashed descriptor word, even on beats it marks as failed, so both functions are exercised on the same beat. The walker must give code 3 with the read's address in every such case. The bench judges this against its own arithmetic walk over the same hashed memory. That walk also predicts the number of reads, so a walk that continued past an aborted read is caught.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int GRAN_LOG2 = 12;
  localparam int STRIDE    = GRAN_LOG2 - 3;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLAT  = 2'd1,
    FLT_PERM  = 2'd2,
    FLT_ABORT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    DK_BAD,
    DK_TABLE,
    DK_BLOCK,
    DK_PAGE
  } dkind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } wstate_e;

  // bit position of the lowest address bit resolved at a level
  function automatic logic [5:0] lvl_shift(input logic [1:0] lvl);
    return 6'(GRAN_LOG2 + STRIDE * (3 - int'(lvl)));
  endfunction
endpackage

// File: rtl/ptw_region_sel.sv
module ptw_region_sel import ptw_pkg::*; #(
  parameter int PA_W = 48
) (
  input  logic [63:0]     va,
  input  logic [5:0]      tsz0,
  input  logic [5:0]      tsz1,
  input  logic            tbi0,
  input  logic            tbi1,
  input  logic            off0,
  input  logic            off1,
  input  logic [63:0]     ttb0,
  input  logic [63:0]     ttb1,
  output logic            sel_fault,
  output logic [1:0]      start_lvl,
  output logic [6:0]      in_size,
  output logic [PA_W-1:0] base
);
  logic       tbi, hit0, hit1, use1, miss, bad_size;
  logic [5:0] tsz;
  logic [2:0] q;
  logic [6:0] mbits;

  always_comb begin
    tbi  = va[55] ? tbi1 : tbi0;
    hit0 = (tsz0 != 6'd0);
    hit1 = (tsz1 != 6'd0);
    for (int i = 0; i < 64; i++) begin
      if (!(tbi && i >= 56)) begin
        if (i >= 64 - int'(tsz0) && va[i])  hit0 = 1'b0;
        if (i >= 64 - int'(tsz1) && !va[i]) hit1 = 1'b0;
      end
    end
    use1 = 1'b0;
    miss = 1'b0;
    if (hit0)               use1 = 1'b0;
    else if (hit1)          use1 = 1'b1;
    else if (tsz0 == 6'd0)  use1 = 1'b0;
    else if (tsz1 == 6'd0)  use1 = 1'b1;
    else                    miss = 1'b1;

    tsz      = use1 ? tsz1 : tsz0;
    in_size  = 7'd64 - {1'b0, tsz};
    bad_size = (in_size > 7'd48) || (in_size < 7'd13);
    // (in_size - 4) / STRIDE as a compare chain
    if (in_size >= 7'd40)      q = 3'd4;
    else if (in_size >= 7'd31) q = 3'd3;
    else if (in_size >= 7'd22) q = 3'd2;
    else                       q = 3'd1;
    start_lvl = 2'(3'd4 - q);
    mbits     = in_size - 7'(q) * 7'(STRIDE);
    base      = (use1 ? ttb1[PA_W-1:0] : ttb0[PA_W-1:0]) & ({PA_W{1'b1}} << mbits);
    sel_fault = miss | (use1 ? off1 : off0) | bad_size;
  end

  logic unused_hi;
  assign unused_hi = ^{ttb0[63:PA_W], ttb1[63:PA_W]};
endmodule

// File: rtl/ptw_desc_addr.sv
module ptw_desc_addr import ptw_pkg::*; #(
  parameter int PA_W = 48
) (
  input  logic [63:0]     va,
  input  logic [6:0]      in_size,
  input  logic [1:0]      lvl,
  input  logic [PA_W-1:0] base,
  output logic [PA_W-1:0] daddr
);
  logic [63:0] masked;
  logic [8:0]  idx;

  always_comb begin
    masked = va & ~({64{1'b1}} << in_size);
    idx    = 9'(masked >> lvl_shift(lvl));
    daddr  = base + PA_W'({idx, 3'b000});
  end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode import ptw_pkg::*; #(
  parameter int PA_W = 48
) (
  input  logic [63:0]     desc,
  input  logic [1:0]      lvl,
  input  logic            wr,
  input  logic [63:0]     va,
  output dkind_e          kind,
  output logic            ro,
  output logic            perm_fail,
  output logic [PA_W-1:0] nxt_base,
  output logic [63:0]     oaddr
);
  logic [63:0] low;

  always_comb begin
    if (!desc[0])       kind = DK_BAD;
    else if (desc[1])   kind = (lvl == 2'd3) ? DK_PAGE : DK_TABLE;
    else                kind = (lvl == 2'd3) ? DK_BAD  : DK_BLOCK;
    ro        = (kind == DK_TABLE) ? desc[62] : desc[7];
    perm_fail = wr && ro && (kind != DK_BAD);
    nxt_base  = {desc[PA_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
    low       = ~({64{1'b1}} << lvl_shift(lvl));
    oaddr     = ({{(64-PA_W){1'b0}}, desc[PA_W-1:0]} & ~low) | (va & low);
  end

  logic unused_bits;
  assign unused_bits = ^{desc[63], desc[61:PA_W]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      cfg_tsz0,
  input  logic [5:0]      cfg_tsz1,
  input  logic            cfg_tbi0,
  input  logic            cfg_tbi1,
  input  logic            cfg_off0,
  input  logic            cfg_off1,
  input  logic [63:0]     cfg_base0,
  input  logic [63:0]     cfg_base1,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_addr,
  input  logic            req_write,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [1:0]      res_fault,
  output logic [63:0]     res_oaddr,
  output logic [63:0]     res_mask,
  output logic [1:0]      res_perm,
  output logic [PA_W-1:0] res_fault_addr
);
  localparam logic [63:0] PG_MASK = 64'((64'd1 << GRAN_LOG2) - 1);

  wstate_e         state;
  logic [63:0]     va_q;
  logic            wr_q;
  logic [1:0]      lvl_q;
  logic [6:0]      ins_q;
  logic [PA_W-1:0] base_q;
  fault_e          fault_q;
  logic [63:0]     oaddr_q;
  logic [1:0]      perm_q;
  logic [PA_W-1:0] faddr_q;

  logic            sel_fault;
  logic [1:0]      sel_lvl;
  logic [6:0]      sel_ins;
  logic [PA_W-1:0] sel_base;
  logic [PA_W-1:0] daddr;
  dkind_e          kind;
  logic            ro, perm_fail;
  logic [PA_W-1:0] nxt_base;
  logic [63:0]     leaf_oaddr;

  ptw_region_sel #(.PA_W(PA_W)) u_sel (
    .va(req_addr), .tsz0(cfg_tsz0), .tsz1(cfg_tsz1), .tbi0(cfg_tbi0), .tbi1(cfg_tbi1),
    .off0(cfg_off0), .off1(cfg_off1), .ttb0(cfg_base0), .ttb1(cfg_base1),
    .sel_fault(sel_fault), .start_lvl(sel_lvl), .in_size(sel_ins), .base(sel_base)
  );

  ptw_desc_addr #(.PA_W(PA_W)) u_addr (
    .va(va_q), .in_size(ins_q), .lvl(lvl_q), .base(base_q), .daddr(daddr)
  );

  ptw_desc_decode #(.PA_W(PA_W)) u_dec (
    .desc(mem_rsp_data), .lvl(lvl_q), .wr(wr_q), .va(va_q),
    .kind(kind), .ro(ro), .perm_fail(perm_fail), .nxt_base(nxt_base), .oaddr(leaf_oaddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      lvl_q   <= '0;
      ins_q   <= '0;
      base_q  <= '0;
      fault_q <= FLT_NONE;
      oaddr_q <= '0;
      perm_q  <= '0;
      faddr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_addr;
          wr_q   <= req_write;
          lvl_q  <= sel_lvl;
          ins_q  <= sel_ins;
          base_q <= sel_base;
          if (sel_fault) begin
            fault_q <= FLT_XLAT;
            oaddr_q <= '0;
            perm_q  <= '0;
            faddr_q <= '0;
            state   <= ST_DONE;
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          oaddr_q <= '0;
          perm_q  <= '0;
          faddr_q <= daddr;
          state   <= ST_DONE;
          if (mem_rsp_err) begin
            fault_q <= FLT_ABORT;
          end else if (kind == DK_BAD) begin
            fault_q <= FLT_XLAT;
          end else if (perm_fail) begin
            fault_q <= FLT_PERM;
          end else if (kind == DK_TABLE) begin
            base_q <= nxt_base;
            lvl_q  <= lvl_q + 2'd1;
            state  <= ST_ISSUE;
          end else begin
            fault_q <= FLT_NONE;
            oaddr_q <= leaf_oaddr;
            perm_q  <= {~ro, 1'b1};
            faddr_q <= '0;
          end
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == ST_IDLE);
  assign mem_req_valid  = (state == ST_ISSUE);
  assign mem_req_addr   = daddr;
  assign res_valid      = (state == ST_DONE);
  assign res_fault      = fault_q;
  assign res_oaddr      = oaddr_q;
  assign res_mask       = PG_MASK;
  assign res_perm       = perm_q;
  assign res_fault_addr = faddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_err,
  input logic            res_valid,
  input logic            res_ready,
  input logic [1:0]      res_fault,
  input logic [63:0]     res_oaddr,
  input logic [1:0]      res_perm,
  input logic [PA_W-1:0] res_fault_addr
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend <= 1'b1;
    else if (mem_rsp_valid)               pend <= 1'b0;
  end

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_fault) && $stable(res_oaddr)
      && $stable(res_perm) && $stable(res_fault_addr));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11
  single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !mem_req_valid);

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && mem_rsp_valid && mem_rsp_err |=> res_valid && res_fault == 2'd3
      && res_fault_addr == $past(mem_req_addr));

  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_perm == 2'd0 && res_oaddr == 64'd0);

  // R7
  ok_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 2'd0 |-> res_perm[0]);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
  .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
  .res_oaddr(res_oaddr), .res_perm(res_perm), .res_fault_addr(res_fault_addr)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  tsz0 = '0, tsz1 = '0;
  logic        tbi0 = 1'b0, tbi1 = 1'b0, off0 = 1'b0, off1 = 1'b0;
  logic [63:0] base0 = '0, base1 = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [63:0] mem_rsp_data;
  logic        res_valid, res_ready = 1'b0;
  logic [1:0]  res_fault, res_perm;
  logic [63:0] res_oaddr, res_mask;
  logic [47:0] res_fault_addr;

  int checks = 0;
  int errors = 0;
  int reads  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_tsz0(tsz0), .cfg_tsz1(tsz1), .cfg_tbi0(tbi0), .cfg_tbi1(tbi1),
    .cfg_off0(off0), .cfg_off1(off1), .cfg_base0(base0), .cfg_base1(base1),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_oaddr(res_oaddr), .res_mask(res_mask), .res_perm(res_perm),
    .res_fault_addr(res_fault_addr)
  );

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x >> 29);
    y = y * 64'hBF58_476D_1CE4_E5B9;
    y = y ^ (y >> 32);
    return y;
  endfunction

  function automatic bit mem_abort(input logic [47:0] pa);
    logic [63:0] h;
    h = mix({16'h5a5a, pa});
    return h[63:59] == 5'd0;
  endfunction

  function automatic logic [63:0] mem_word(input logic [47:0] pa);
    logic [63:0] h, d;
    h = mix({16'h5a5a, pa});
    d = h;
    d[62] = h[62] & h[61] & h[60];
    if (h[3:0] == 4'd0)      d[1:0] = 2'b00;
    else if (h[3:0] == 4'd1) d[1:0] = 2'b10;
    else if (h[3:0] < 4'd4)  d[1:0] = 2'b01;
    else                     d[1:0] = 2'b11;
    return d;
  endfunction

  // memory model: stalls every third offered request, answers one cycle after grant
  initial begin
    logic [47:0] pa;
    bit pend;
    int stall;
    pend = 0; stall = 0; pa = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      mem_req_ready = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(pa);
        mem_rsp_err   = mem_abort(pa);
        pend = 0;
      end else if (mem_req_valid) begin
        stall++;
        if (stall % 3 != 0) begin
          mem_req_ready = 1'b1;
          pa = mem_req_addr;
          pend = 1;
          reads++;
        end
      end
    end
  end

  function automatic void ref_walk(input logic [63:0] va, input logic wr,
      output logic [1:0] f, output logic [63:0] oa, output logic [1:0] pm,
      output logic [47:0] fa, output int nrd, output string rq);
    logic t, h0, h1;
    int top, ins, lvl, s, r, z0, z1;
    logic [63:0] base, d, da, idx, lm;
    f = 2'd0; oa = '0; pm = 2'd0; fa = '0; nrd = 0; rq = "R9";
    z0 = int'(tsz0); z1 = int'(tsz1);
    t = va[55] ? tbi1 : tbi0;
    top = t ? 55 : 63;
    h0 = (z0 != 0); h1 = (z1 != 0);
    for (int i = 64 - z0; i <= top; i++) if (va[i])  h0 = 1'b0;
    for (int i = 64 - z1; i <= top; i++) if (!va[i]) h1 = 1'b0;
    if (h0) r = 0;
    else if (h1) r = 1;
    else if (z0 == 0) r = 0;
    else if (z1 == 0) r = 1;
    else begin f = 2'd1; rq = "R1"; return; end
    if (r == 0 ? off0 : off1) begin f = 2'd1; rq = "R2"; return; end
    ins = 64 - (r == 0 ? z0 : z1);
    if (ins < 13 || ins > 48) begin f = 2'd1; rq = "R3"; return; end
    lvl = 4 - (ins - 4) / 9;
    base = (r == 0 ? base0 : base1) & 64'h0000_FFFF_FFFF_FFFF;
    base = base & ~((64'd1 << (ins - 9 * (4 - lvl))) - 64'd1);
    for (int l = lvl; l <= 3; l++) begin
      s   = 12 + 9 * (3 - l);
      lm  = (64'd1 << s) - 64'd1;
      idx = ((va & ((64'd1 << ins) - 64'd1)) >> s) & 64'h1FF;
      da  = (base + idx * 8) & 64'h0000_FFFF_FFFF_FFFF;
      nrd++;
      if (mem_abort(da[47:0])) begin f = 2'd3; fa = da[47:0]; rq = "R5"; return; end
      d = mem_word(da[47:0]);
      if (!d[0] || (d[1:0] == 2'b01 && l == 3)) begin
        f = 2'd1; fa = da[47:0]; rq = "R6"; return;
      end
      if (d[1] && l < 3) begin
        if (wr && d[62]) begin f = 2'd2; fa = da[47:0]; rq = "R8"; return; end
        base = d & 64'h0000_FFFF_FFFF_F000;
      end else begin
        if (wr && d[7]) begin f = 2'd2; fa = da[47:0]; rq = "R7"; return; end
        oa = ((d & 64'h0000_FFFF_FFFF_FFFF) & ~lm) | (va & lm);
        pm = {~d[7], 1'b1};
        return;
      end
    end
  endfunction

  task automatic run_walk(input logic [63:0] va, input logic wr, input int hold);
    logic [1:0]  ef, epm, af, apm;
    logic [63:0] eoa, aoa;
    logic [47:0] efa, afa;
    int          enrd;
    string       rq;
    ref_walk(va, wr, ef, eoa, epm, efa, enrd, rq);
    reads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    af = res_fault; aoa = res_oaddr; apm = res_perm; afa = res_fault_addr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      checks++;
      if (!res_valid || res_fault != af || res_oaddr != aoa || res_perm != apm
          || res_fault_addr != afa) begin
        errors++;
        $display("FAIL R11 held result changed: valid=%0b fault=%0d oa=%h expected fault=%0d oa=%h",
                 res_valid, res_fault, res_oaddr, af, aoa);
      end
    end
    checks++;
    if (af != ef || aoa != eoa || apm != epm || afa != efa || reads != enrd
        || (ef == 2'd0 && res_mask != 64'hFFF)) begin
      errors++;
      $display("FAIL %s va=%h wr=%0b: fault=%0d oa=%h perm=%0d fa=%h reads=%0d mask=%h expected fault=%0d oa=%h perm=%0d fa=%h reads=%0d (R4 reads)",
               rq, va, wr, af, aoa, apm, afa, reads, res_mask, ef, eoa, epm, efa, enrd);
    end
    if (ef != 2'd0) begin
      checks++;
      if (apm != 2'd0 || aoa != 64'd0) begin
        errors++;
        $display("FAIL R10 fault result not cleared: perm=%0d oa=%h expected 0 0", apm, aoa);
      end
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic set_cfg(input int c);
    base0 = mix(64'(c + 17));
    base1 = mix(64'(c + 117));
    case (c)
      0: begin tsz0 = 6'd16; tsz1 = 6'd16; tbi0 = 0; tbi1 = 0; off0 = 0; off1 = 0; end
      1: begin tsz0 = 6'd25; tsz1 = 6'd25; tbi0 = 1; tbi1 = 0; off0 = 0; off1 = 0; end
      2: begin tsz0 = 6'd34; tsz1 = 6'd0;  tbi0 = 0; tbi1 = 1; off0 = 0; off1 = 0; end
      3: begin tsz0 = 6'd0;  tsz1 = 6'd43; tbi0 = 1; tbi1 = 1; off0 = 0; off1 = 0; end
      4: begin tsz0 = 6'd20; tsz1 = 6'd30; tbi0 = 0; tbi1 = 0; off0 = 1; off1 = 0; end
      5: begin tsz0 = 6'd39; tsz1 = 6'd22; tbi0 = 1; tbi1 = 1; off0 = 0; off1 = 1; end
      6: begin tsz0 = 6'd10; tsz1 = 6'd55; tbi0 = 0; tbi1 = 0; off0 = 0; off1 = 0; end
      default: begin tsz0 = 6'd43; tsz1 = 6'd16; tbi0 = 0; tbi1 = 1; off0 = 0; off1 = 0; end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog expired: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    // R11 reset state
    if (req_ready !== 1'b1 || res_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: ready=%b res_valid=%b mem_valid=%b expected 1 0 0",
               req_ready, res_valid, mem_req_valid);
    end
    for (int c = 0; c < 8; c++) begin
      set_cfg(c);
      for (int k = 0; k < 48; k++) begin
        logic [63:0] r, va, lowm;
        int L;
        r    = mix(64'(c * 1000 + k));
        L    = 24 + 8 * ((k / 4) % 4);
        lowm = (64'd1 << L) - 64'd1;
        case (k % 4)
          0: va = r & lowm;
          1: va = r | ~lowm;
          2: va = r;
          default: begin
            va = r[63] ? (r | ~lowm) : (r & lowm);
            va[63:56] = r[31:24];
          end
        endcase
        run_walk(va, r[9], (k % 8 == 5) ? 3 : 0);
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule